// File: doc/BRIEF.md
# Three-Stage Fetch Sequencer

This block moves instructions of a 32-bit core through fetch, decode and execute stages over one memory port that serves both instruction and data traffic. It owns the program counter and its incrementer, presents the fetch address, captures each fetched word into a decode register, and then moves it into an execute register. An instruction in execute reads back a program counter value that is computed from its own address, as if the counter had moved two fetches past it.

The two top bits of each instruction word form a class field. The class tells the sequencer whether the instruction is plain single-cycle work, a store that needs the memory port for a second execute cycle, or a branch. A branch is taken when `br_go` is high while a branch is in execute. The taken branch loads `br_target` into the program counter and drops the two younger instructions. The `half_mode` input selects 16-bit instruction spacing in place of 32-bit spacing.

Top module: `tri_stage_seq`

## Requirements
- R1: While `rst_n` is low, `mem_addr` is 0, and `ex_valid`, `retire` and `dport_busy` are low.
- R2: A fetch completes (`fetch_done` high) only when `mem_wait` is low, no store is in execute and no branch is being taken. Each completed fetch advances `mem_addr` by 4 when `half_mode`=0 and by 2 when `half_mode`=1. Otherwise `mem_addr` holds.
- R3: Instructions retire in program order. Each word reaches execute with its own fetch address. With no waits, stores or taken branches, one instruction retires every clock.
- R4: In the first execute cycle, `ex_pc_read` equals `ex_addr`+8 when `half_mode`=0 and `ex_addr`+4 when `half_mode`=1, and `ex_pc_undef` is low.
- R5: A store (class field `ex_instr[31:30]`=2'b01) stays in execute for two cycles. The first cycle has `retire` low. The second cycle has `dport_busy` high, `retire` high, `ex_pc_undef` high and `ex_pc_read` equal to `ex_addr`+12 (32-bit) or `ex_addr`+6 (16-bit).
- R6: During both store cycles no fetch completes. The decode and execute contents hold through the first cycle.
- R7: A branch (class 2'b10) in execute with `br_go` high loads `br_target` as the next fetch address and invalidates decode and execute. With `mem_wait` low, execute then shows exactly two empty cycles before the target instruction. `br_go` has no effect while a non-branch is in execute.
- R8: Class 2'b00 and class 2'b11 are both handled as single-cycle instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_mode | input | 1 | 1 selects 16-bit instruction spacing |
| mem_rdata | input | 32 | Instruction word read at `mem_addr` |
| mem_wait | input | 1 | Memory not ready this cycle |
| br_go | input | 1 | Branch condition for a branch in execute |
| br_target | input | 32 | Branch destination address |
| mem_addr | output | 32 | Current fetch address (program counter) |
| fetch_done | output | 1 | A fetch completes at the coming edge |
| dport_busy | output | 1 | Memory port carries store data this cycle |
| ex_valid | output | 1 | Execute stage holds an instruction |
| ex_instr | output | 32 | Instruction word in execute |
| ex_addr | output | 32 | Address of the instruction in execute |
| ex_pc_read | output | 32 | Program counter value seen by execute |
| ex_pc_undef | output | 1 | `ex_pc_read` is the late, undefined value |
| retire | output | 1 | Instruction in execute completes this cycle |

## Verification
The bench aims at the seams of the pipeline. It covers a taken branch whose two younger instructions must vanish, and it covers stores that must freeze upstream stages and block fetch for two cycles. It also covers waits that land in the middle of these events and mode changes made together with a taken branch. A design that flushed only one stage would retire a wrong-path address. A design that let fetch run during a store would skip a word or advance `mem_addr` one step too far. A design that built the read-back value from the live counter instead of the instruction's own address would report +8 only when no bubbles were present. `br_go` is held high across non-branch code, so a design that redirected on the request alone would break program order at once.

// File: rtl/seq_pkg.sv
package seq_pkg;
  parameter int unsigned XLEN = 32;
  localparam int unsigned CLS_TOP = XLEN - 1;

  typedef enum logic [1:0] {
    CLS_ALU    = 2'b00,
    CLS_STORE  = 2'b01,
    CLS_BRANCH = 2'b10,
    CLS_ALU_B  = 2'b11
  } op_class_e;

  // Distance between consecutive instructions.
  function automatic logic [XLEN-1:0] fetch_step(input logic half);
    return half ? XLEN'(2) : XLEN'(4);
  endfunction

  // Counter value seen by execute: two steps ahead, three on the late cycle.
  function automatic logic [XLEN-1:0] pc_view(input logic [XLEN-1:0] own,
                                               input logic half,
                                               input logic late);
    logic [XLEN-1:0] s;
    s = fetch_step(half);
    return late ? own + s + s + s : own + s + s;
  endfunction

  function automatic op_class_e class_of(input logic [XLEN-1:0] w);
    return op_class_e'(w[CLS_TOP -: 2]);
  endfunction
endpackage

// File: rtl/seq_fetch.sv
module seq_fetch
  import seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            half_mode,
  input  logic            mem_wait,
  input  logic            port_busy,
  input  logic            ex_hold,
  input  logic            redirect,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc_q,
  output logic            fetch_done
);
  logic pipe_open;

  assign pipe_open  = !port_busy && !ex_hold;
  assign fetch_done = pipe_open && !mem_wait && !redirect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc_q <= '0;
    else if (redirect)   pc_q <= target;
    else if (fetch_done) pc_q <= pc_q + fetch_step(half_mode);
  end

  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_done && !redirect) |=> (pc_q == $past(pc_q)));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> (pc_q == $past(pc_q) + fetch_step($past(half_mode))));

  p_redirect_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (pc_q == $past(target)));
endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_done,
  input  logic            redirect,
  input  logic            ex_hold,
  input  logic [XLEN-1:0] fetch_word,
  input  logic [XLEN-1:0] fetch_addr,
  output logic            dec_valid,
  output logic [XLEN-1:0] dec_instr,
  output logic [XLEN-1:0] dec_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_instr <= '0;
      dec_addr  <= '0;
    end else if (redirect) begin
      dec_valid <= 1'b0;
    end else if (!ex_hold) begin
      dec_valid <= fetch_done;
      if (fetch_done) begin
        dec_instr <= fetch_word;
        dec_addr  <= fetch_addr;
      end
    end
  end

  p_dec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_hold && !redirect) |=> ($stable(dec_valid) && $stable(dec_addr) && $stable(dec_instr)));

  p_dec_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !dec_valid);
endmodule

// File: rtl/seq_execute.sv
module seq_execute
  import seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            half_mode,
  input  logic            br_go,
  input  logic            dec_valid,
  input  logic [XLEN-1:0] dec_instr,
  input  logic [XLEN-1:0] dec_addr,
  output logic            ex_valid,
  output logic [XLEN-1:0] ex_instr,
  output logic [XLEN-1:0] ex_addr,
  output logic            ex_hold,
  output logic            port_busy,
  output logic            redirect,
  output logic            retire,
  output logic [XLEN-1:0] pc_read,
  output logic            pc_undef
);
  op_class_e cls;
  logic      phase_q;
  logic      is_store;

  assign cls       = class_of(ex_instr);
  assign is_store  = ex_valid && (cls == CLS_STORE);
  assign ex_hold   = is_store && !phase_q;
  assign port_busy = is_store && phase_q;
  assign redirect  = ex_valid && (cls == CLS_BRANCH) && br_go;
  assign retire    = ex_valid && !ex_hold;
  assign pc_undef  = ex_valid && phase_q;
  assign pc_read   = pc_view(ex_addr, half_mode, phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_valid <= 1'b0;
      ex_instr <= '0;
      ex_addr  <= '0;
      phase_q  <= 1'b0;
    end else if (redirect) begin
      ex_valid <= 1'b0;
      phase_q  <= 1'b0;
    end else if (ex_hold) begin
      phase_q  <= 1'b1;
    end else begin
      ex_valid <= dec_valid;
      ex_instr <= dec_instr;
      ex_addr  <= dec_addr;
      phase_q  <= 1'b0;
    end
  end

  p_store_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ex_hold |=> (port_busy && pc_undef && $stable(ex_addr)));

  p_late_leaves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    port_busy |=> !pc_undef);

  p_ex_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !ex_valid);
endmodule

// File: rtl/tri_stage_seq.sv
module tri_stage_seq
  import seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            half_mode,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_wait,
  input  logic            br_go,
  input  logic [XLEN-1:0] br_target,
  output logic [XLEN-1:0] mem_addr,
  output logic            fetch_done,
  output logic            dport_busy,
  output logic            ex_valid,
  output logic [XLEN-1:0] ex_instr,
  output logic [XLEN-1:0] ex_addr,
  output logic [XLEN-1:0] ex_pc_read,
  output logic            ex_pc_undef,
  output logic            retire
);
  logic            ex_hold;
  logic            redirect;
  logic            dec_valid;
  logic [XLEN-1:0] dec_instr;
  logic [XLEN-1:0] dec_addr;

  seq_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .half_mode(half_mode), .mem_wait(mem_wait),
    .port_busy(dport_busy), .ex_hold(ex_hold), .redirect(redirect),
    .target(br_target), .pc_q(mem_addr), .fetch_done(fetch_done)
  );

  seq_decode u_decode (
    .clk(clk), .rst_n(rst_n), .fetch_done(fetch_done), .redirect(redirect),
    .ex_hold(ex_hold), .fetch_word(mem_rdata), .fetch_addr(mem_addr),
    .dec_valid(dec_valid), .dec_instr(dec_instr), .dec_addr(dec_addr)
  );

  seq_execute u_execute (
    .clk(clk), .rst_n(rst_n), .half_mode(half_mode), .br_go(br_go),
    .dec_valid(dec_valid), .dec_instr(dec_instr), .dec_addr(dec_addr),
    .ex_valid(ex_valid), .ex_instr(ex_instr), .ex_addr(ex_addr),
    .ex_hold(ex_hold), .port_busy(dport_busy), .redirect(redirect),
    .retire(retire), .pc_read(ex_pc_read), .pc_undef(ex_pc_undef)
  );

  p_busy_nofetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dport_busy |-> !fetch_done);

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (mem_addr == '0 && !ex_valid && !retire));

  p_retire_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> ex_valid);
endmodule

// File: tb/tri_stage_seq_tb_top.sv
module tri_stage_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        half_mode;
  logic [31:0] mem_rdata;
  logic        mem_wait;
  logic        br_go;
  logic [31:0] br_target;
  logic [31:0] mem_addr;
  logic        fetch_done, dport_busy, ex_valid, ex_pc_undef, retire;
  logic [31:0] ex_instr, ex_addr, ex_pc_read;

  int n_chk = 0;
  int n_fail = 0;
  int kind = 0;          // 0 all single, 1 mixed, 3 all branch, 4 all store
  int wait_pct = 0;      // chance of mem_wait in percent
  int go_mode = 0;       // 0 random, 1 forced high, 2 forced low
  bit flip_ok = 0;
  bit win_on = 0;
  int win_cnt = 0;
  int gap = 0;
  bit st_pend = 0;
  logic [31:0] exp_fa, exp_next;

  always #2.5 clk = ~clk;

  tri_stage_seq dut_i (
    .clk(clk), .rst_n(rst_n), .half_mode(half_mode), .mem_rdata(mem_rdata),
    .mem_wait(mem_wait), .br_go(br_go), .br_target(br_target),
    .mem_addr(mem_addr), .fetch_done(fetch_done), .dport_busy(dport_busy),
    .ex_valid(ex_valid), .ex_instr(ex_instr), .ex_addr(ex_addr),
    .ex_pc_read(ex_pc_read), .ex_pc_undef(ex_pc_undef), .retire(retire)
  );

  function automatic logic [31:0] mk_instr(input logic [31:0] a, input int k);
    logic [1:0]  c;
    logic [31:0] h;
    h = a * 32'h9E3779B1;
    case (k)
      0: c = 2'b00;
      3: c = 2'b10;
      4: c = 2'b01;
      default: case (h[30:28])
        3'd0, 3'd1: c = 2'b01;
        3'd2:       c = 2'b10;
        3'd3:       c = 2'b11;
        default:    c = 2'b00;
      endcase
    endcase
    return {c, a[29:0]};
  endfunction

  function automatic logic [31:0] want_view(input logic [31:0] a, input logic h, input logic late);
    if (late) return a + (h ? 32'd6 : 32'd12);
    return a + (h ? 32'd4 : 32'd8);
  endfunction

  always_comb mem_rdata = mk_instr(mem_addr, kind);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive();
    logic taking;
    mem_wait = ($urandom % 100) < wait_pct;
    case (go_mode)
      1: br_go = 1'b1;
      2: br_go = 1'b0;
      default: br_go = $urandom % 2;
    endcase
    taking = ex_valid && ex_instr[31:30] == 2'b10 && br_go;
    if (taking && flip_ok && ($urandom % 4) == 0) half_mode = ~half_mode;
    br_target = ($urandom % 4096) & (half_mode ? 32'hFFFF_FFFE : 32'hFFFF_FFFC);
  endtask

  task automatic predict();
    logic taking, st, expf;
    logic [31:0] s;
    s = half_mode ? 32'd2 : 32'd4;
    taking = ex_valid && ex_instr[31:30] == 2'b10 && br_go;
    st = ex_valid && ex_instr[31:30] == 2'b01;
    expf = !mem_wait && !st && !taking;
    chk(fetch_done == expf, "R2 fetch gate", {31'd0, fetch_done}, {31'd0, expf});
    if (ex_valid && !(st && !st_pend_cur())) exp_next = taking ? br_target : ex_addr + s;
    exp_fa = taking ? br_target : (expf ? exp_fa + s : exp_fa);
    if (taking && wait_pct == 0) gap = 3;
  endtask

  // st_pend is set on the first store cycle, so at predict time it marks the current cycle as first.
  function automatic bit st_pend_cur();
    return !st_pend;
  endfunction

  task automatic observe();
    logic is_st;
    chk(mem_addr == exp_fa, "R2 fetch address", mem_addr, exp_fa);
    if (gap != 0) begin
      if (gap > 1) chk(!ex_valid, "R7 flush bubble", {31'd0, ex_valid}, 32'd0);
      else         chk(ex_valid, "R7 target arrival", {31'd0, ex_valid}, 32'd1);
      gap--;
    end
    if (!ex_valid) begin
      chk(!retire && !dport_busy, "R3 idle execute", {30'd0, retire, dport_busy}, 32'd0);
      st_pend = 0;
      return;
    end
    chk(ex_instr[29:0] == ex_addr[29:0], "R3 word/address pairing", ex_instr, ex_addr);
    is_st = ex_instr[31:30] == 2'b01;
    if (is_st && !st_pend) begin
      chk(!retire && !dport_busy && !ex_pc_undef, "R5 store first cycle",
          {29'd0, retire, dport_busy, ex_pc_undef}, 32'd0);
      chk(ex_pc_read == want_view(ex_addr, half_mode, 1'b0), "R4 store first view",
          ex_pc_read, want_view(ex_addr, half_mode, 1'b0));
      st_pend = 1;
    end else if (is_st) begin
      chk(retire && dport_busy && ex_pc_undef, "R5 store second cycle",
          {29'd0, retire, dport_busy, ex_pc_undef}, 32'd7);
      chk(ex_pc_read == want_view(ex_addr, half_mode, 1'b1), "R5 late view",
          ex_pc_read, want_view(ex_addr, half_mode, 1'b1));
      st_pend = 0;
    end else begin
      chk(retire && !dport_busy && !ex_pc_undef, "R8 single-cycle class handling",
          {29'd0, retire, dport_busy, ex_pc_undef}, 32'd4);
      chk(ex_pc_read == want_view(ex_addr, half_mode, 1'b0), "R4 first-cycle view",
          ex_pc_read, want_view(ex_addr, half_mode, 1'b0));
      st_pend = 0;
    end
    if (retire) begin
      chk(ex_addr == exp_next, "R3 R7 program order", ex_addr, exp_next);
      if (win_on) win_cnt++;
    end
  endtask

  task automatic step();
    @(negedge clk);
    observe();
    drive();
    #1;
    predict();
  endtask

  task automatic do_reset(input logic half);
    rst_n = 1'b0;
    half_mode = half;
    mem_wait = 1'b0;
    br_go = 1'b0;
    br_target = '0;
    repeat (2) @(negedge clk);
    chk(mem_addr == 0 && !ex_valid && !retire && !dport_busy, "R1 reset state",
        mem_addr | {28'd0, ex_valid, retire, dport_busy, 1'b0}, 32'd0);
    rst_n = 1'b1;
    exp_fa = '0;
    exp_next = '0;
    st_pend = 0;
    gap = 0;
    drive();
    #1;
    predict();
  endtask

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd2718);
    // Straight-line code, br_go held high to show it is ignored (R7), 32-bit throughput (R3).
    kind = 0; wait_pct = 0; go_mode = 1; flip_ok = 0;
    do_reset(1'b0);
    repeat (4) step();
    win_on = 1; win_cnt = 0;
    repeat (30) step();
    win_on = 0;
    chk(win_cnt == 30, "R3 one retire per clock", win_cnt, 30);
    // 16-bit spacing and view offset (R2, R4).
    do_reset(1'b1);
    repeat (4) step();
    win_on = 1; win_cnt = 0;
    repeat (20) step();
    win_on = 0;
    chk(win_cnt == 20, "R3 one retire per clock 16-bit", win_cnt, 20);
    // Back-to-back stores (R5, R6).
    kind = 4;
    do_reset(1'b0);
    repeat (40) step();
    // Every instruction a taken branch: two-bubble refill (R7).
    kind = 3; go_mode = 1;
    do_reset(1'b0);
    repeat (40) step();
    // Mixed code with waits, random branch conditions and mode changes at branches.
    kind = 1; wait_pct = 20; go_mode = 0; flip_ok = 1;
    do_reset(1'b0);
    repeat (2500) step();
    do_reset(1'b1);
    repeat (1500) step();
    // Mixed code with no waits so that refill gaps are checked among stores.
    wait_pct = 0;
    do_reset(1'b0);
    repeat (600) step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule